// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit operands and a carry-in using purely combinational logic. The carry chain is split into four 4-bit groups. Each group makes a generate term and a propagate term for every bit and then works out all of its internal carries at once, in flattened sum-of-products form. It also reduces its bit terms to a single group generate and group propagate.

A second lookahead level takes the four group generate/propagate pairs and the carry-in and produces the carry into each group at once. No carry ripples from one group to the next. The logic depth is fixed at eight gate levels:

- one level for the bit terms,
- two for the group terms,
- two for the group carries,
- two for the bit carries inside a group,
- one for the sum.

The block-wide generate and propagate are brought out, so a wider adder can place this block under a third lookahead level.

Top module: `cla16_adder`

## Requirements
- R1: Each bit position forms generate as a AND b and propagate as a OR b. Because propagate is an OR, each sum bit is formed from a separate a XOR b half-sum: a bit where both operands are 1 and the carry into it is 0 yields sum bit 0.
- R2: `sum` equals (op_a + op_b + carry_in) modulo 2^16 for every operand pair and either carry-in value.
- R3: `carry_out` equals bit 16 of op_a + op_b + carry_in.
- R4: `blk_gen` is 1 exactly when op_a + op_b, with carry-in taken as 0, is 2^16 or more.
- R5: `blk_prop` is 1 exactly when every bit position has op_a or op_b set. When `blk_prop` and `carry_in` are both 1, `carry_out` is 1.
- R6: With both operands all ones and carry-in 1, `sum` is 16'hFFFF and `carry_out` is 1. With both operands all ones and carry-in 0, `sum` is 16'hFFFE and `carry_out` is 1.
- R7: A carry that leaves one 4-bit group reaches the next group correctly. For example, 16'h000F + 16'h0001 gives 16'h0010, and 16'h0FFF + 16'h0001 gives 16'h1000.
- R8: The block has no clock and no state. All outputs follow the inputs within the same evaluation, and with all inputs zero every output is zero.
- R9: The carry into every bit position, in both lookahead levels, equals what a ripple recurrence g | p & c from the carry below it would give.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum modulo 2^16 |
| carry_out | output | 1 | Carry out of bit 15 |
| blk_gen | output | 1 | Block generate, used for cascading |
| blk_prop | output | 1 | Block propagate, used for cascading |

## Verification
The immediate assertions check the following on every input change:

- the flattened carries at both levels match a ripple recurrence;
- each group's sum and carry match the group's own arithmetic;
- the full 17-bit result matches op_a + op_b + carry_in;
- block generate, and block propagate combined with the carry-in, each force a carry-out.

What only the bench scenarios can show is that each output takes the correct absolute value. This covers the exact meaning of the block generate and block propagate, the all-ones corner cases, and carries crossing group boundaries. To show these, the bench sweeps every 8-bit pattern pair, replicated across the groups, under both carry-in values, and adds random and directed vectors.

// File: rtl/cla_pkg.sv
// Package cla_pkg
// Shared types for the lookahead adder tree.
// Assumes: single-bit generate/propagate terms per group.
package cla_pkg;
    typedef struct packed {
        logic gen;
        logic prop;
    } gp_t;
endpackage

// File: rtl/cla_bit_terms.sv
// Module cla_bit_terms
// Forms per-bit generate (AND), propagate (OR) and half-sum (XOR).
// Assumes: nothing; one gate level per output bit.
module cla_bit_terms #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] gen,
    output logic [W-1:0] prop,
    output logic [W-1:0] half
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // per-bit terms, one gate each
        assign gen[i]  = a[i] & b[i];
        assign prop[i] = a[i] | b[i];
        assign half[i] = a[i] ^ b[i];
    end

    // R1: generate implies propagate, and half-sum never set with generate
    always_comb begin
        for (int i = 0; i < W; i++) begin
            a_terms_r1: assert (!(gen[i] && (half[i] || !prop[i])))
                else $error("R1 bit terms inconsistent at %0d", i);
        end
    end
endmodule

// File: rtl/cla_lookahead.sv
// Module cla_lookahead
// Flattened lookahead unit: from N generate/propagate pairs and a
// carry-in, forms the carry into every position, the carry out, and
// the combined generate/propagate. Each carry is a two-level AND-OR.
// Assumes: N small enough that the flattened products stay narrow.
module cla_lookahead #(
    parameter int N = 4
) (
    input  logic [N-1:0] gen,
    input  logic [N-1:0] prop,
    input  logic         cin,
    output logic [N-1:0] carry,
    output logic         cout,
    output logic         grp_gen,
    output logic         grp_prop
);
    logic [N:0] c_all;

    assign c_all[0] = cin;

    for (genvar i = 1; i <= N; i++) begin : g_carry
        // sum of products for the carry into position i
        always_comb begin
            logic acc;
            logic term;
            acc = 1'b0;
            for (int j = 0; j < i; j++) begin
                term = gen[j];
                for (int k = j + 1; k < i; k++) term = term & prop[k];
                acc = acc | term;
            end
            term = cin;
            for (int k = 0; k < i; k++) term = term & prop[k];
            c_all[i] = acc | term;
        end
    end

    // combined generate, same shape as the top carry without cin
    always_comb begin
        logic acc;
        logic term;
        acc = 1'b0;
        for (int j = 0; j < N; j++) begin
            term = gen[j];
            for (int k = j + 1; k < N; k++) term = term & prop[k];
            acc = acc | term;
        end
        grp_gen = acc;
    end

    // combined propagate: every position propagates
    assign grp_prop = &prop;
    assign carry    = c_all[N-1:0];
    assign cout     = c_all[N];

    // R9: flattened carries agree with the ripple recurrence
    always_comb begin
        for (int i = 0; i < N; i++) begin
            a_ripple_equiv_r9: assert (c_all[i+1] == (gen[i] | (prop[i] & c_all[i])))
                else $error("R9 carry %0d differs from recurrence", i + 1);
        end
    end
endmodule

// File: rtl/cla_group.sv
// Module cla_group
// One lookahead group: bit terms, internal carries from cla_lookahead,
// sums from the XOR half-sum, and a group generate/propagate pair.
// Assumes: the carry-in comes from the upper lookahead level.
module cla_group
    import cla_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output gp_t          gp
);
    logic [W-1:0] gen_w, prop_w, half_w, carry_w;
    logic         cout_w, ggen_w, gprop_w;

    cla_bit_terms #(.W(W)) u_terms (
        .a(a), .b(b), .gen(gen_w), .prop(prop_w), .half(half_w)
    );

    cla_lookahead #(.N(W)) u_look (
        .gen(gen_w), .prop(prop_w), .cin(cin),
        .carry(carry_w), .cout(cout_w),
        .grp_gen(ggen_w), .grp_prop(gprop_w)
    );

    // sum bits from XOR half-sum and local carry
    assign sum     = half_w ^ carry_w;
    assign gp.gen  = ggen_w;
    assign gp.prop = gprop_w;

    // R2: group result matches group arithmetic
    always_comb begin
        a_group_sum_r2: assert ({cout_w, sum} == ({1'b0, a} + {1'b0, b} + (W+1)'(cin)))
            else $error("R2 group sum mismatch");
    end
endmodule

// File: rtl/cla16_adder.sv
// Module cla16_adder
// 16-bit two-level lookahead adder: four groups, plus a second lookahead
// level that forms group carries from the group generate/propagate.
// Assumes: purely combinational use; the block-level generate and
// propagate feed an outer lookahead level when cascaded.
module cla16_adder
    import cla_pkg::*;
#(
    parameter int GROUP_W = 4,
    parameter int GROUPS  = 4,
    localparam int WIDTH  = GROUP_W * GROUPS
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             blk_gen,
    output logic             blk_prop
);
    gp_t [GROUPS-1:0]   grp_terms;
    logic [GROUPS-1:0]  grp_gen, grp_prop, grp_cin;

    for (genvar g = 0; g < GROUPS; g++) begin : g_group
        cla_group #(.W(GROUP_W)) u_grp (
            .a  (op_a[g*GROUP_W +: GROUP_W]),
            .b  (op_b[g*GROUP_W +: GROUP_W]),
            .cin(grp_cin[g]),
            .sum(sum[g*GROUP_W +: GROUP_W]),
            .gp (grp_terms[g])
        );
        // unpack group terms for the second level
        assign grp_gen[g]  = grp_terms[g].gen;
        assign grp_prop[g] = grp_terms[g].prop;
    end

    cla_lookahead #(.N(GROUPS)) u_second (
        .gen(grp_gen), .prop(grp_prop), .cin(carry_in),
        .carry(grp_cin), .cout(carry_out),
        .grp_gen(blk_gen), .grp_prop(blk_prop)
    );

    // R2/R3: full result matches operand arithmetic
    always_comb begin
        a_full_sum_r3: assert ({carry_out, sum} == ({1'b0, op_a} + {1'b0, op_b} + (WIDTH+1)'(carry_in)))
            else $error("R3 full result mismatch");
    end

    // R4: block generate forces a carry out
    always_comb begin
        a_gen_cout_r4: assert (!blk_gen || carry_out)
            else $error("R4 generate without carry out");
    end

    // R5: block propagate with carry-in forces a carry out
    always_comb begin
        a_prop_cout_r5: assert (!(blk_prop && carry_in) || carry_out)
            else $error("R5 propagate and carry-in without carry out");
    end
endmodule

// File: tb/cla16_adder_test.sv
module cla16_adder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a = '0, op_b = '0;
    logic        carry_in = 1'b0;
    logic [15:0] sum;
    logic        carry_out, blk_gen, blk_prop;
    int          errors = 0, checks = 0, cyc = 0;

    always #5 clk = ~clk;

    cla16_adder uut (
        .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
        .sum(sum), .carry_out(carry_out),
        .blk_gen(blk_gen), .blk_prop(blk_prop)
    );

    // watchdog
    always @(posedge clk) begin
        if (rst_n) cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%h expected=%h (a=%h b=%h cin=%b)",
                     req, act, exp, op_a, op_b, carry_in);
        end
    endtask

    task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c);
        logic [16:0] full, nocin;
        op_a = a; op_b = b; carry_in = c;
        #1;
        full  = {1'b0, a} + {1'b0, b} + {16'd0, c};
        nocin = {1'b0, a} + {1'b0, b};
        chk("R2 sum", {16'd0, sum}, {16'd0, full[15:0]});
        chk("R3 carry_out", {31'd0, carry_out}, {31'd0, full[16]});
        chk("R4 blk_gen", {31'd0, blk_gen}, {31'd0, nocin[16]});
        chk("R5 blk_prop", {31'd0, blk_prop}, {31'd0, &(a | b)});
    endtask

    initial begin
        logic [15:0] ra, rb;
        #2;
        // R8: zero inputs give zero outputs without any clock
        chk("R8 zero sum", {16'd0, sum}, 32'd0);
        chk("R8 zero flags", {29'd0, carry_out, blk_gen, blk_prop}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R6: all-ones corners
        apply(16'hFFFF, 16'hFFFF, 1'b1);
        chk("R6 ones cin1", {15'd0, carry_out, sum}, {15'd0, 1'b1, 16'hFFFF});
        apply(16'hFFFF, 16'hFFFF, 1'b0);
        chk("R6 ones cin0", {15'd0, carry_out, sum}, {15'd0, 1'b1, 16'hFFFE});
        apply(16'hFFFF, 16'h0000, 1'b1);
        chk("R5 prop chain", {15'd0, carry_out, sum}, {15'd0, 1'b1, 16'h0000});

        // R7: carries across group boundaries
        apply(16'h000F, 16'h0001, 1'b0);
        chk("R7 group0->1", {16'd0, sum}, 32'h0010);
        apply(16'h0FFF, 16'h0001, 1'b0);
        chk("R7 group2->3", {16'd0, sum}, 32'h1000);
        apply(16'h00FF, 16'h0000, 1'b1);
        chk("R7 cin through two groups", {16'd0, sum}, 32'h0100);

        // R1: both bits set, no carry in -> sum bit 0 (XOR half-sum)
        apply(16'h0001, 16'h0001, 1'b0);
        chk("R1 xor half-sum", {16'd0, sum}, 32'h0002);
        apply(16'h0101, 16'h0101, 1'b0);
        chk("R1 xor half-sum multi", {16'd0, sum}, 32'h0202);

        // R2/R3/R4/R5/R9: replicated 8-bit sweep under both carry-ins
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                apply({x[7:0], x[7:0]}, {y[7:0], y[7:0]}, 1'b0);
                apply({x[7:0], y[7:0]}, {y[7:0], x[7:0]}, 1'b1);
            end
        end

        // R2/R3: random vectors
        for (int n = 0; n < 3000; n++) begin
            ra = 16'($urandom);
            rb = 16'($urandom);
            apply(ra, rb, n[0]);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule